// File: doc/BRIEF.md
# Cascadable Up/Down Timer Pair with Wrap Toggle Latch

This block holds two 16-bit up/down counters. The core counter can count in three ways: on ticks of a fixed divide-by-8 prescaler, on those ticks only while a gate pin is high, or on chosen edges of an external count pin. Each time the core counter wraps past its end in either direction, a toggle latch inverts. The latch value is driven out on a pin.

The auxiliary counter advances on a chosen edge of its own external pin, or on a chosen edge of the core's toggle latch. Counting on both latch edges makes the pair one 32-bit counter. Counting on a single latch edge puts the latch between the two halves and gives a 33-bit counter. Each counter has its own count direction. Only a latch change caused by a wrap can clock the auxiliary counter. A software load of the latch never produces a count.

A flat register port (write strobe, address, data; separate read address with a combinational read) reaches both count values and both configuration words. Both external count pins go through a two-flop synchronizer. They are then sampled once every four clocks, so a level must be held for at least four clocks to be recognised.

Top module: `tmr_cascade`

## Requirements
- R1: After reset, all four registers read 0 and `toggleOut` is 0. Register addresses: 0 holds the core count, 1 the auxiliary count, 2 the core configuration, 3 the auxiliary configuration.
- R2: Core configuration bit 0 is run and bit 1 is down (1 = count down). Bits [3:2] are the mode: 00 timer, 01 gated, 10 counter, 11 hold. In timer mode with run=1, the core count steps once every 8 clocks; the first step comes 8 clocks after run is set. With run=0 the count holds.
- R3: In gated mode, the core count steps on prescaler ticks only while `gatePin` is high. While it is low the count holds.
- R4: In counter mode, the core count steps on edges of `corePin` chosen by core configuration bits [5:4]: 01 rising, 10 falling, 11 both, 00 none.
- R5: A pin level held for 8 clocks between changes is seen as exactly one edge, after a two-flop synchronizer and a sampler that runs every 4 clocks.
- R6: Both counters wrap modulo 2^16. Overflow goes from 0xFFFF to 0x0000 counting up; underflow goes from 0x0000 to 0xFFFF counting down.
- R7: The toggle latch inverts on every core overflow and underflow. It drives `toggleOut` and reads back in core configuration bit 6.
- R8: Auxiliary configuration bit 0 is run, bit 1 is down, and bits [4:2] select the count source. In pin mode, 001 counts rising, 010 falling and 011 both edges of `auxPin`. 000 and 100 disable counting.
- R9: Select 111 advances the auxiliary count once for every core wrap, forming a 32-bit counter.
- R10: Select 101 counts on rising latch edges and 110 on falling latch edges. Either way the auxiliary count advances on every second core wrap, forming a 33-bit counter.
- R11: Writing the core configuration with bit 7 = 1 loads the latch from bit 6. This load never advances the auxiliary count. Writes with bit 7 = 0 leave the latch unchanged.
- R12: The core and auxiliary count directions are independent. The cascade works with the core in timer, gated or counter mode.
- R13: A write to a count register takes priority over a count step in the same cycle. The prescaler phase is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Combinational read data |
| corePin | input | 1 | Core external count input |
| auxPin | input | 1 | Auxiliary external count input |
| gatePin | input | 1 | Gate for core gated-timer mode |
| toggleOut | output | 1 | Core wrap toggle latch |

## Verification
The bench builds the block with its defaults: 16-bit counters, a prescaler of 8 and a pin sampling period of 4. With a prescaler of 8, the cycle of each timer step can be predicted exactly. That lets a register write be placed on the very edge of a step, so the write-priority case can be reached. A 16-bit width would make natural wraps far too slow to reach. The bench therefore preloads the core count at 0xFFFF or 0x0000 before each run, so every latch edge, 32-bit and 33-bit cascade step and opposite-direction case is reached within a few clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'b00,
    MODE_GATED   = 2'b01,
    MODE_COUNTER = 2'b10,
    MODE_HOLD    = 2'b11
  } coreMode_e;

  // bit layout of the core configuration word: [5:4] edge, [3:2] mode, [1] down, [0] run
  typedef struct packed {
    logic [1:0] edgeSel;
    coreMode_e  mode;
    logic       down;
    logic       run;
  } coreCfg_t;

  // bit layout of the auxiliary configuration word: [4:2] source select, [1] down, [0] run
  typedef struct packed {
    logic [2:0] sel;
    logic       down;
    logic       run;
  } auxCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic coreStep;
    logic auxPinStep;
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_CORE_CNT = 2'd0;
  localparam logic [1:0] ADDR_AUX_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CORE_CFG = 2'd2;
  localparam logic [1:0] ADDR_AUX_CFG  = 2'd3;

  localparam int LATCH_BIT      = 6;
  localparam int LATCH_LOAD_BIT = 7;

endpackage

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic sampleEn,
  output logic rise,
  output logic fall
);
  logic [1:0] syncQ;
  logic       smpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      smpQ  <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pin};
      if (sampleEn) begin
        smpQ <= syncQ[1];
        rise <= syncQ[1] & ~smpQ;
        fall <= ~syncQ[1] & smpQ;
      end else begin
        rise <= 1'b0;
        fall <= 1'b0;
      end
    end
  end

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (!rstN) rise |=> !rise);
  // R5
  single_fall_chk: assert property (@(posedge clk) disable iff (!rstN) fall |=> !fall);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRESCALE   = 8,
  parameter int SAMPLE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreRun,
  input  coreMode_e  coreMode,
  input  logic [1:0] coreEdgeSel,
  input  logic       auxRun,
  input  logic [2:0] auxSel,
  input  logic       corePin,
  input  logic       auxPin,
  input  logic       gatePin,
  output tmrStrobe_t strobe
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SMP_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [SMP_W-1:0] smpCnt;
  logic [1:0]       gateQ;
  logic             sampleEn;
  logic             tick;
  logic             coreRise, coreFall, auxRise, auxFall;
  logic             edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      smpCnt <= '0;
      gateQ  <= '0;
    end else begin
      gateQ  <= {gateQ[0], gatePin};
      smpCnt <= (smpCnt == SMP_LAST) ? '0 : smpCnt + 1'b1;
      if (!coreRun || preCnt == PRE_LAST) preCnt <= '0;
      else                                preCnt <= preCnt + 1'b1;
    end
  end

  assign sampleEn = (smpCnt == SMP_LAST);
  assign tick     = coreRun && (preCnt == PRE_LAST);

  tmr_pin_sampler u_coreSmp (
    .clk(clk), .rstN(rstN), .pin(corePin), .sampleEn(sampleEn),
    .rise(coreRise), .fall(coreFall)
  );

  tmr_pin_sampler u_auxSmp (
    .clk(clk), .rstN(rstN), .pin(auxPin), .sampleEn(sampleEn),
    .rise(auxRise), .fall(auxFall)
  );

  assign edgeHit = (coreEdgeSel[0] & coreRise) | (coreEdgeSel[1] & coreFall);

  always_comb begin
    strobe = '0;
    if (coreRun) begin
      unique case (coreMode)
        MODE_TIMER:   strobe.coreStep = tick;
        MODE_GATED:   strobe.coreStep = tick & gateQ[1];
        MODE_COUNTER: strobe.coreStep = edgeHit;
        default:      strobe.coreStep = 1'b0;
      endcase
    end
    strobe.auxPinStep = auxRun && !auxSel[2] &&
                        ((auxSel[0] & auxRise) | (auxSel[1] & auxFall));
  end

  // R2
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
  // R3
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreMode == MODE_GATED && !$past(gatePin, 2)) |-> !strobe.coreStep);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   rdAddr,
  input  tmrStrobe_t   strobe,
  output logic [W-1:0] rdData,
  output coreCfg_t     coreCfg,
  output auxCfg_t      auxCfg,
  output logic         toggleOut
);
  localparam int CORE_CFG_W = $bits(coreCfg_t);
  localparam int AUX_CFG_W  = $bits(auxCfg_t);
  localparam int CORE_PAD   = W - CORE_CFG_W - 1;
  localparam int AUX_PAD    = W - AUX_CFG_W;

  logic [W-1:0] coreCnt, auxCnt;
  logic         latchQ;
  logic         coreWr, auxWr, coreCfgWr, auxCfgWr, latchLoad;
  logic         coreAdv, coreWrap, latchRise, latchFall, auxLatchHit, auxAdv;

  assign coreWr    = wrEn && wrAddr == ADDR_CORE_CNT;
  assign auxWr     = wrEn && wrAddr == ADDR_AUX_CNT;
  assign coreCfgWr = wrEn && wrAddr == ADDR_CORE_CFG;
  assign auxCfgWr  = wrEn && wrAddr == ADDR_AUX_CFG;
  assign latchLoad = coreCfgWr && wrData[LATCH_LOAD_BIT];

  assign coreAdv   = strobe.coreStep && !coreWr;
  assign coreWrap  = coreAdv && (coreCfg.down ? (coreCnt == '0) : (coreCnt == '1));
  assign latchRise = coreWrap && !latchQ && !latchLoad;
  assign latchFall = coreWrap &&  latchQ && !latchLoad;

  assign auxLatchHit = auxCfg.sel[2] &&
                       ((auxCfg.sel[0] & latchRise) | (auxCfg.sel[1] & latchFall));
  assign auxAdv = auxCfg.run && (strobe.auxPinStep || auxLatchHit) && !auxWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreCnt <= '0;
      auxCnt  <= '0;
      latchQ  <= 1'b0;
      coreCfg <= '0;
      auxCfg  <= '0;
    end else begin
      if (coreWr)       coreCnt <= wrData;
      else if (coreAdv) coreCnt <= coreCfg.down ? coreCnt - 1'b1 : coreCnt + 1'b1;

      if (auxWr)        auxCnt <= wrData;
      else if (auxAdv)  auxCnt <= auxCfg.down ? auxCnt - 1'b1 : auxCnt + 1'b1;

      if (latchLoad)     latchQ <= wrData[LATCH_BIT];
      else if (coreWrap) latchQ <= ~latchQ;

      if (coreCfgWr) coreCfg <= coreCfg_t'(wrData[CORE_CFG_W-1:0]);
      if (auxCfgWr)  auxCfg  <= auxCfg_t'(wrData[AUX_CFG_W-1:0]);
    end
  end

  assign toggleOut = latchQ;

  always_comb begin
    unique case (rdAddr)
      ADDR_CORE_CNT: rdData = coreCnt;
      ADDR_AUX_CNT:  rdData = auxCnt;
      ADDR_CORE_CFG: rdData = {{CORE_PAD{1'b0}}, latchQ, coreCfg};
      default:       rdData = {{AUX_PAD{1'b0}}, auxCfg};
    endcase
  end

  // R6
  core_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.coreStep && !coreWr && !coreCfg.down && coreCnt == '1) |=> coreCnt == '0);
  // R6
  core_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.coreStep && !coreWr && coreCfg.down && coreCnt == '0) |=> coreCnt == '1);
  // R7
  latch_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrap && !coreCfgWr) |=> toggleOut != $past(toggleOut));
  // R13
  core_wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWr |=> coreCnt == $past(wrData));
  // R11
  latch_load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchLoad && auxCfg.sel[2] && !auxWr) |=> $stable(auxCnt));

endmodule

// File: rtl/tmr_cascade.sv
module tmr_cascade
  import tmr_pkg::*;
#(
  parameter int W          = 16,
  parameter int PRESCALE   = 8,
  parameter int SAMPLE_DIV = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   rdAddr,
  output logic [W-1:0] rdData,
  input  logic         corePin,
  input  logic         auxPin,
  input  logic         gatePin,
  output logic         toggleOut
);
  tmrStrobe_t strobe;
  coreCfg_t   coreCfg;
  auxCfg_t    auxCfg;

  tmr_ctrl #(.PRESCALE(PRESCALE), .SAMPLE_DIV(SAMPLE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .coreRun(coreCfg.run), .coreMode(coreCfg.mode), .coreEdgeSel(coreCfg.edgeSel),
    .auxRun(auxCfg.run), .auxSel(auxCfg.sel),
    .corePin(corePin), .auxPin(auxPin), .gatePin(gatePin),
    .strobe(strobe)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .strobe(strobe), .rdData(rdData),
    .coreCfg(coreCfg), .auxCfg(auxCfg), .toggleOut(toggleOut)
  );

endmodule

// File: tb/sim_tmr_cascade.sv
module sim_tmr_cascade;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        corePin = 1'b0;
  logic        auxPin = 1'b0;
  logic        gatePin = 1'b0;
  logic        toggleOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cascade u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .corePin(corePin), .auxPin(auxPin),
    .gatePin(gatePin), .toggleOut(toggleOut)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; corePin = 1'b0; auxPin = 1'b0; gatePin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // called at a negedge; write lands on the next posedge; returns at the negedge after it
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulse(ref logic pin, input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; repeat (8) @(negedge clk);
      pin = 1'b0; repeat (8) @(negedge clk);
    end
    repeat (16) @(negedge clk);
  endtask

  // force exactly one core wrap in timer mode
  task automatic oneWrap(input bit down);
    wr(2'd2, 16'h0000);
    wr(2'd0, down ? 16'h0000 : 16'hFFFF);
    wr(2'd2, down ? 16'h0003 : 16'h0001);
    repeat (8) @(negedge clk);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    doReset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset toggleOut", {15'b0, toggleOut}, 16'h0000);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    doReset();
    wr(2'd2, 16'h0001);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check("R2 timer up 40 clocks", v, 16'd5);
    wr(2'd2, 16'h0000);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check("R2 stopped holds", v, 16'd5);
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h0003);
    repeat (16) @(negedge clk);
    rd(2'd0, v); check("R2 timer down", v, 16'd1);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    doReset();
    oneWrap(1'b0);
    rd(2'd0, v); check("R6 overflow to zero", v, 16'h0000);
    check("R7 latch after overflow", {15'b0, toggleOut}, 16'h0001);
    rd(2'd2, v); check("R7 latch readback bit 6", v, 16'h0040);
    oneWrap(1'b1);
    rd(2'd0, v); check("R6 underflow to FFFF", v, 16'hFFFF);
    check("R7 latch after underflow", {15'b0, toggleOut}, 16'h0000);
  endtask

  task automatic t_gated();
    logic [15:0] v;
    doReset();
    wr(2'd2, 16'h0005);
    repeat (80) @(negedge clk);
    rd(2'd0, v); check("R3 gate low holds", v, 16'd0);
    gatePin = 1'b1;
    wr(2'd2, 16'h0000);
    repeat (4) @(negedge clk);
    wr(2'd2, 16'h0005);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check("R3 gate high counts", v, 16'd5);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    doReset();
    wr(2'd2, 16'h0019);
    pulse(corePin, 3);
    rd(2'd0, v); check("R4 R5 rising edges", v, 16'd3);
    wr(2'd0, 16'd0); wr(2'd2, 16'h0039);
    pulse(corePin, 3);
    rd(2'd0, v); check("R4 R5 both edges", v, 16'd6);
    wr(2'd0, 16'd0); wr(2'd2, 16'h0029);
    pulse(corePin, 2);
    rd(2'd0, v); check("R4 falling edges", v, 16'd2);
    wr(2'd0, 16'd0); wr(2'd2, 16'h0009);
    pulse(corePin, 2);
    rd(2'd0, v); check("R4 no edge selected", v, 16'd0);
  endtask

  task automatic t_auxPin();
    logic [15:0] v;
    logic [15:0] cfgs [5] = '{16'h0005, 16'h0009, 16'h000D, 16'h0001, 16'h0011};
    logic [15:0] exps [5] = '{16'd2, 16'd2, 16'd4, 16'd0, 16'd0};
    doReset();
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, 16'd0);
      wr(2'd3, cfgs[i]);
      pulse(auxPin, 2);
      rd(2'd1, v); check("R8 aux pin select", v, exps[i]);
    end
  endtask

  task automatic t_cascade32();
    logic [15:0] v;
    doReset();
    wr(2'd3, 16'h001D);
    for (int i = 0; i < 4; i++) oneWrap(1'b0);
    rd(2'd1, v); check("R9 both latch edges", v, 16'd4);
  endtask

  task automatic t_cascade33();
    logic [15:0] v;
    doReset();
    wr(2'd3, 16'h0015);
    for (int i = 0; i < 4; i++) oneWrap(1'b0);
    rd(2'd1, v); check("R10 rising latch edge", v, 16'd2);
    doReset();
    wr(2'd3, 16'h0019);
    oneWrap(1'b0);
    rd(2'd1, v); check("R10 falling edge first wrap", v, 16'd0);
    oneWrap(1'b0);
    rd(2'd1, v); check("R10 falling edge second wrap", v, 16'd1);
  endtask

  task automatic t_latchWrite();
    logic [15:0] v;
    doReset();
    wr(2'd3, 16'h001D);
    wr(2'd2, 16'h00C0);
    check("R11 latch loaded high", {15'b0, toggleOut}, 16'h0001);
    rd(2'd1, v); check("R11 load high no count", v, 16'd0);
    wr(2'd2, 16'h0080);
    check("R11 latch loaded low", {15'b0, toggleOut}, 16'h0000);
    rd(2'd1, v); check("R11 load low no count", v, 16'd0);
    oneWrap(1'b0);
    rd(2'd1, v); check("R11 wrap still counts", v, 16'd1);
  endtask

  task automatic t_direction();
    logic [15:0] v;
    doReset();
    wr(2'd3, 16'h001F);
    oneWrap(1'b0);
    rd(2'd1, v); check("R12 aux down on core up", v, 16'hFFFF);
    oneWrap(1'b1);
    rd(2'd1, v); check("R12 aux down on core down", v, 16'hFFFE);
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0019);
    pulse(corePin, 1);
    rd(2'd0, v); check("R12 core counter-mode wrap", v, 16'h0000);
    rd(2'd1, v); check("R12 cascade in counter mode", v, 16'hFFFD);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    doReset();
    wr(2'd2, 16'h0001);
    repeat (7) @(negedge clk);
    wr(2'd0, 16'h1234);
    rd(2'd0, v); check("R13 write wins over step", v, 16'h1234);
    repeat (7) @(negedge clk);
    rd(2'd0, v); check("R13 before next tick", v, 16'h1234);
    repeat (1) @(negedge clk);
    rd(2'd0, v); check("R13 prescaler phase kept", v, 16'h1235);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_wrap();
    t_gated();
    t_counter();
    t_auxPin();
    t_cascade32();
    t_cascade33();
    t_latchWrite();
    t_direction();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule